// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional operation goes ahead. A 4-bit condition code selects one of sixteen tests. The tests read the current overflow, carry, zero, sign and parity flags. The result is a single bit: true means the condition holds.

That bit is purely combinational. It is shared by every consumer that depends on a condition, such as conditional branches and conditional byte writes. Codes come in pairs. The low bit of a code flips the result of the even code just below it. The evaluator therefore only builds eight base tests and XORs them with bit 0.

Alongside the evaluator sits a small registered flag path. It holds a carry bit and a string-direction bit. Single-cycle commands complement, clear or set the carry, or clear or set the direction.

Top module: `cc_unit`

## Requirements
- R1: Code 0 is true when overflow is 1, and code 1 is true when overflow is 0.
- R2: Code 2 is true when carry is 1 (unsigned below), and code 3 is true when carry is 0.
- R3: Code 4 is true when zero is 1 (equal), and code 5 is true when zero is 0.
- R4: Code 6 is true when carry or zero is 1 (unsigned below-or-equal), and code 7 is the negation of code 6.
- R5: Codes 8 and 9 are true when sign is 1 and 0 respectively. Codes 10 and 11 are true when parity is 1 and 0 respectively.
- R6: Code 12 is true when sign differs from overflow (signed less), and code 13 is the negation of code 12.
- R7: Code 14 is true when zero is 1 or sign differs from overflow (signed less-or-equal), and code 15 is the negation of code 14.
- R8: For every flag combination, the result for an odd code is the inverse of the result for the even code one below it.
- R9: `cond_true_o` follows `cc_i` and the flag inputs in the same cycle, with no register in the path.
- R10: After reset, `carry_o` and `dir_o` are both 0.
- R11: Carry commands are encoded on `flag_cmd_i` as 1 = complement, 2 = clear and 3 = set. Each takes effect at the clock edge that samples it. A carry command leaves `dir_o` unchanged.
- R12: Direction commands are encoded on `flag_cmd_i` as 4 = clear (forward stepping) and 5 = set (backward stepping). Each takes effect at the sampling edge. A direction command leaves `carry_o` unchanged.
- R13: Code 0 (no command) and the reserved codes 6 and 7 leave both `carry_o` and `dir_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cc_i | input | 4 | Condition code to evaluate |
| flag_of_i | input | 1 | Overflow flag |
| flag_cf_i | input | 1 | Carry flag |
| flag_zf_i | input | 1 | Zero flag |
| flag_sf_i | input | 1 | Sign flag |
| flag_pf_i | input | 1 | Parity flag |
| cond_true_o | output | 1 | Condition holds |
| flag_cmd_i | input | 3 | Flag command (one per cycle, encoded) |
| carry_o | output | 1 | Registered carry bit |
| dir_o | output | 1 | Registered direction bit (1 = backward) |

## Verification
The compound tests get both a true case and a false case. For codes 6/7 the bench exercises carry and zero one at a time. For codes 12 to 15 it covers sign equal to overflow and sign different from overflow. A design that used AND for the unsigned below-or-equal test, or compared sign with carry, would fail on one of those vectors.

An exhaustive sweep over all codes and flag combinations catches a parity that is wrong in any single pair. On the register side, two complements in a row must return carry to its old value. Reserved command codes must not disturb either bit. A decoder that treats code 7 as "set" or code 6 as "clear" would show a changed output.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CC_W   = 4;
    localparam int BASE_N = 1 << (CC_W - 1);
    localparam int CMD_W  = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE  = 3'd0,
        CMD_CPL_C = 3'd1,
        CMD_CLR_C = 3'd2,
        CMD_SET_C = 3'd3,
        CMD_CLR_D = 3'd4,
        CMD_SET_D = 3'd5
    } flag_cmd_e;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic zer;
        logic sgn;
        logic par;
    } flags_t;

    typedef struct packed {
        logic cry;
        logic dir;
    } ctl_flags_t;

endpackage

// File: rtl/cc_base_eval.sv
module cc_base_eval
    import cc_pkg::*;
(
    input  flags_t             flags_i,
    output logic [BASE_N-1:0]  base_o
);

    logic lt_signed;

    always_comb begin
        lt_signed = flags_i.sgn ^ flags_i.ovf;
    end

    // One base test per even code; index is code bits 3:1.
    for (genvar g = 0; g < BASE_N; g++) begin : g_base
        always_comb begin
            unique case (g)
                0:       base_o[g] = flags_i.ovf;
                1:       base_o[g] = flags_i.cry;
                2:       base_o[g] = flags_i.zer;
                3:       base_o[g] = flags_i.cry | flags_i.zer;
                4:       base_o[g] = flags_i.sgn;
                5:       base_o[g] = flags_i.par;
                6:       base_o[g] = lt_signed;
                default: base_o[g] = flags_i.zer | lt_signed;
            endcase
        end
    end

endmodule

// File: rtl/cc_select.sv
module cc_select
    import cc_pkg::*;
(
    input  logic [CC_W-1:0]    cc_i,
    input  logic [BASE_N-1:0]  base_i,
    output logic               true_o
);

    logic [CC_W-2:0] pair_idx;
    logic            invert;

    always_comb begin
        pair_idx = cc_i[CC_W-1:1];
        invert   = cc_i[0];
        true_o   = base_i[pair_idx] ^ invert;
    end

endmodule

// File: rtl/flag_cmd_reg.sv
module flag_cmd_reg
    import cc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CMD_W-1:0]  cmd_i,
    output ctl_flags_t        state_o
);

    ctl_flags_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (cmd_i)
            CMD_CPL_C: state_d.cry = ~state_q.cry;
            CMD_CLR_C: state_d.cry = 1'b0;
            CMD_SET_C: state_d.cry = 1'b1;
            CMD_CLR_D: state_d.dir = 1'b0;
            CMD_SET_D: state_d.dir = 1'b1;
            default:   state_d     = state_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/cc_unit.sv
module cc_unit
    import cc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CC_W-1:0]   cc_i,
    input  logic              flag_of_i,
    input  logic              flag_cf_i,
    input  logic              flag_zf_i,
    input  logic              flag_sf_i,
    input  logic              flag_pf_i,
    output logic              cond_true_o,
    input  logic [CMD_W-1:0]  flag_cmd_i,
    output logic              carry_o,
    output logic              dir_o
);

    flags_t             flags;
    logic [BASE_N-1:0]  base;
    ctl_flags_t         ctl;

    always_comb begin
        flags.ovf = flag_of_i;
        flags.cry = flag_cf_i;
        flags.zer = flag_zf_i;
        flags.sgn = flag_sf_i;
        flags.par = flag_pf_i;
    end

    cc_base_eval u_base (
        .flags_i (flags),
        .base_o  (base)
    );

    cc_select u_sel (
        .cc_i   (cc_i),
        .base_i (base),
        .true_o (cond_true_o)
    );

    flag_cmd_reg u_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cmd_i   (flag_cmd_i),
        .state_o (ctl)
    );

    assign carry_o = ctl.cry;
    assign dir_o   = ctl.dir;

endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [3:0] cc_i,
    input logic       flag_of_i,
    input logic       flag_cf_i,
    input logic       flag_zf_i,
    input logic       flag_sf_i,
    input logic       flag_pf_i,
    input logic       cond_true_o,
    input logic [2:0] flag_cmd_i,
    input logic       carry_o,
    input logic       dir_o
);

    a_r1_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_i == 4'd0) |-> (cond_true_o == flag_of_i));

    a_r2_carry_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_i == 4'd3) |-> (cond_true_o == !flag_cf_i));

    a_r3_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_i == 4'd4) |-> (cond_true_o == flag_zf_i));

    a_r4_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_i == 4'd7 && (flag_cf_i || flag_zf_i)) |-> !cond_true_o);

    a_r6_less: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_i == 4'd12 && flag_sf_i != flag_of_i) |-> cond_true_o);

    a_r7_greater: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_i == 4'd15 && flag_zf_i) |-> !cond_true_o);

    a_r10_reset_state: assert property (@(posedge clk_i)
        !rst_ni |=> (!carry_o && !dir_o));

    a_r11_set_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i == 3'd3) |=> carry_o);

    a_r11_clear_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i == 3'd2) |=> !carry_o);

    a_r11_cpl_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i == 3'd1) |=> (carry_o != $past(carry_o)));

    a_r11_dir_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i inside {3'd1, 3'd2, 3'd3}) |=> $stable(dir_o));

    a_r12_set_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i == 3'd5) |=> (dir_o && $stable(carry_o)));

    a_r12_clear_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i == 3'd4) |=> (!dir_o && $stable(carry_o)));

    a_r13_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_cmd_i inside {3'd0, 3'd6, 3'd7}) |=> ($stable(carry_o) && $stable(dir_o)));

endmodule

bind cc_unit cc_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cc_i        (cc_i),
    .flag_of_i   (flag_of_i),
    .flag_cf_i   (flag_cf_i),
    .flag_zf_i   (flag_zf_i),
    .flag_sf_i   (flag_sf_i),
    .flag_pf_i   (flag_pf_i),
    .cond_true_o (cond_true_o),
    .flag_cmd_i  (flag_cmd_i),
    .carry_o     (carry_o),
    .dir_o       (dir_o)
);

// File: tb/cc_unit_tb.sv
module cc_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cc;
    logic       f_of, f_cf, f_zf, f_sf, f_pf;
    logic       cond;
    logic [2:0] cmd;
    logic       carry, dir;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    cc_unit u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cc_i        (cc),
        .flag_of_i   (f_of),
        .flag_cf_i   (f_cf),
        .flag_zf_i   (f_zf),
        .flag_sf_i   (f_sf),
        .flag_pf_i   (f_pf),
        .cond_true_o (cond),
        .flag_cmd_i  (cmd),
        .carry_o     (carry),
        .dir_o       (dir)
    );

    // Vector: {code[3:0], of, cf, zf, sf, pf, expected}
    localparam int NV = 22;
    localparam logic [9:0] VEC [NV] = '{
        {4'd0,  5'b10000, 1'b1},
        {4'd0,  5'b01111, 1'b0},
        {4'd1,  5'b00000, 1'b1},
        {4'd2,  5'b01000, 1'b1},
        {4'd3,  5'b01000, 1'b0},
        {4'd4,  5'b00100, 1'b1},
        {4'd5,  5'b00100, 1'b0},
        {4'd6,  5'b00100, 1'b1},
        {4'd6,  5'b01000, 1'b1},
        {4'd6,  5'b10011, 1'b0},
        {4'd7,  5'b00000, 1'b1},
        {4'd7,  5'b01000, 1'b0},
        {4'd8,  5'b00010, 1'b1},
        {4'd9,  5'b00010, 1'b0},
        {4'd10, 5'b00001, 1'b1},
        {4'd11, 5'b00000, 1'b1},
        {4'd12, 5'b00010, 1'b1},
        {4'd12, 5'b10010, 1'b0},
        {4'd13, 5'b00000, 1'b1},
        {4'd14, 5'b00100, 1'b1},
        {4'd14, 5'b10010, 1'b0},
        {4'd15, 5'b10010, 1'b1}
    };

    function automatic string req_of(input logic [3:0] c);
        case (c[3:1])
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            3'd4, 3'd5: return "R5";
            3'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic flag_cmd(input logic [2:0] c);
        @(negedge clk) cmd = c;
        @(negedge clk) cmd = 3'd0;
        #1;
    endtask

    task automatic check_ctl(input string req, input logic ec, input logic ed);
        check(req, carry, ec, "carry");
        check(req, dir, ed, "dir");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic r_even;
        rst_n = 1'b0;
        cc    = '0;
        {f_of, f_cf, f_zf, f_sf, f_pf} = '0;
        cmd   = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_ctl("R10", 1'b0, 1'b0);

        // Table walk (R1..R7); output must settle without a clock edge (R9).
        for (int i = 0; i < NV; i++) begin
            cc = VEC[i][9:6];
            {f_of, f_cf, f_zf, f_sf, f_pf} = VEC[i][5:1];
            #1;
            check(req_of(VEC[i][9:6]), cond, VEC[i][0], $sformatf("vector %0d", i));
        end

        // R8: every pair, every flag combination; R9: no clock between steps.
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 32; f++) begin
                {f_of, f_cf, f_zf, f_sf, f_pf} = f[4:0];
                cc = 4'(2 * p);
                #1;
                r_even = cond;
                cc = 4'(2 * p + 1);
                #1;
                check("R8", cond, ~r_even, $sformatf("pair %0d flags %b", p, f[4:0]));
            end
        end

        // Flag register path.
        flag_cmd(3'd3); check_ctl("R11", 1'b1, 1'b0);
        @(negedge clk); #1; check_ctl("R13", 1'b1, 1'b0);
        flag_cmd(3'd1); check_ctl("R11", 1'b0, 1'b0);
        flag_cmd(3'd1); check_ctl("R11", 1'b1, 1'b0);
        flag_cmd(3'd5); check_ctl("R12", 1'b1, 1'b1);
        flag_cmd(3'd2); check_ctl("R11", 1'b0, 1'b1);
        flag_cmd(3'd6); check_ctl("R13", 1'b0, 1'b1);
        flag_cmd(3'd7); check_ctl("R13", 1'b0, 1'b1);
        flag_cmd(3'd4); check_ctl("R12", 1'b0, 1'b0);
        flag_cmd(3'd3); check_ctl("R11", 1'b1, 1'b0);
        flag_cmd(3'd6); check_ctl("R13", 1'b1, 1'b0);
        flag_cmd(3'd7); check_ctl("R13", 1'b1, 1'b0);
        flag_cmd(3'd4); check_ctl("R12", 1'b1, 1'b0);

        // Reset again from a non-zero state.
        flag_cmd(3'd5);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        check_ctl("R10", 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule